// File: doc/BRIEF.md
# LPI Table Base Register Frame

This block is the per-core redistributor register frame for message-based interrupts (LPIs). It holds four registers. The first is a control word with an LPI-enable bit. The second is a read-only 64-bit type word that describes the core. The other two are 64-bit base registers: one for the LPI property table and one for the LPI pending table. Software reaches these registers with 32-bit or 64-bit accesses on a simple request port. Reads return data in the same cycle as the request. Writes take effect at the next clock edge.

A value written to a base register is first merged with the half it does not replace. It is then cleaned before it is stored. Unsupported memory attributes are replaced with supported ones, and reserved bits are forced to zero. So a later read always returns what the table walker will actually use.

Once LPIs are enabled, both base registers are frozen. A rising enable produces a one-cycle pulse that tells the rest of the redistributor to start using the tables.

Top module: `lpi_redist_frame`

## Requirements
- R1: The LPI-enable bit is bit 0 of the control word at byte offset 0x00. It can be written only when the parameter `HAS_MSI` is 1. When `HAS_MSI` is 0, control writes are ignored and the bit reads as 0.
- R2: `lpi_en_pulse` is high for exactly one cycle, namely the cycle in which `lpi_en` first reads 1 after a control write that changes it from 0 to 1. Writing 1 while the bit is already 1 gives no pulse.
- R3: While `lpi_en` is 1, writes to the property base (offset 0x10) and to the pending base (offset 0x18) leave both registers unchanged.
- R4: With `req_wide`=0, a write replaces bits 31:0 of a base register when address bit 2 is 0, and bits 63:32 when address bit 2 is 1. With `req_wide`=1, a write replaces all 64 bits and address bit 2 is ignored.
- R5: The shareability field is at bits 11:10. The code for outer-shareable (2) is stored as inner-shareable (1). The codes 0 (non-shareable), 1 and 3 are stored unchanged.
- R6: The inner cacheability field is at bits 9:7. The codes for device (0) and non-cacheable (1) are stored as read-allocate write-back (7). All other codes are stored unchanged.
- R7: The outer cacheability field is at bits 58:56. It is stored unchanged only when it is 0 (same as inner) or 1 (non-cacheable). Any other code is stored as 1.
- R8: After a write, some bits are always zero:
  - both base registers: bits 51:48;
  - property base: also bits 63:59, 55:52 and 6:5;
  - pending base: also bit 63, bits 61:59, 55:52, 15:12 and 6:0.
- R9: The type word is at offset 0x08. Its fields are:
  - affinity: `AFFINITY[23:0]` at bits 55:32;
  - core number: `CORE_ID[15:0]` at bits 23:8;
  - last-core flag: bit 4, set when `CORE_ID` equals `CORE_COUNT-1`;
  - physical-LPI flag: bit 0, set when `HAS_MSI` is 1;
  - all other bits: 0.
  Writes to the type word are ignored.
- R10: Reads behave as follows:
  - A 32-bit read returns the half selected by address bit 2 in `rd_data[31:0]`, with bits 63:32 zero.
  - A request with address bits 1:0 not zero, or with any address bit above bit 4 set, reads as zero and its writes are ignored.
  - `rd_data` is zero when no read is requested.
- R11: After a synchronous active-low reset, the control word, both base registers and `lpi_en_pulse` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte offset within the frame |
| req_wdata | input | 64 | Write data; a 32-bit access uses bits 31:0 |
| rd_data | output | 64 | Read data in the request cycle |
| lpi_en | output | 1 | Current LPI-enable state |
| lpi_en_pulse | output | 1 | One-cycle pulse when LPIs become enabled |

## Verification
The bench builds two instances that receive the same requests:
- The first has `HAS_MSI`=1 and is the last of four cores. This makes the enable pulse, the write lockout and both type-word flags reachable.
- The second has `HAS_MSI`=0 and is core 1 of four. Here control writes must be ignored, the base registers stay writable whatever software writes to the control word, and both type-word flags must be clear.

Directed writes with all-ones data and with each attribute code that must be remapped show the cleaning of each field. A long pseudo-random run mixes half and full writes on both instances.

// File: rtl/lpi_frame_pkg.sv
// Shared constants for the LPI table base register frame: slot decode,
// attribute field positions and codes, reserved-bit masks, type-word layout.
package lpi_frame_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;

    // Register slots, selected by byte-address bits 4:3
    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_TYPE = 2'd1,
        SLOT_PROP = 2'd2,
        SLOT_PEND = 2'd3
    } slot_e;

    localparam int SLOT_LO    = 3;
    localparam int SLOT_W     = 2;
    localparam int HALF_BIT   = 2;
    localparam int FRAME_BITS = SLOT_LO + SLOT_W;

    localparam int CTRL_EN_BIT = 0;

    // Attribute field positions
    localparam int SH_LO = 10;
    localparam int SH_W  = 2;
    localparam int IC_LO = 7;
    localparam int IC_W  = 3;
    localparam int OC_LO = 56;
    localparam int OC_W  = 3;

    // Attribute codes
    localparam logic [SH_W-1:0] SH_INNER    = 2'd1;
    localparam logic [SH_W-1:0] SH_OUTER    = 2'd2;
    localparam logic [IC_W-1:0] IC_DEVICE   = 3'd0;
    localparam logic [IC_W-1:0] IC_NONCACHE = 3'd1;
    localparam logic [IC_W-1:0] IC_RAWB     = 3'd7;
    localparam logic [OC_W-1:0] OC_SAME     = 3'd0;
    localparam logic [OC_W-1:0] OC_NONCACHE = 3'd1;

    // Bits always cleared on store
    localparam logic [DATA_W-1:0] PROP_CLR = 64'hF8FF_0000_0000_0060;
    localparam logic [DATA_W-1:0] PEND_CLR = 64'hB8FF_0000_0000_F07F;

    // Type-word layout
    localparam int TY_PLPI_BIT = 0;
    localparam int TY_LAST_BIT = 4;
    localparam int TY_CORE_LO  = 8;
    localparam int TY_AFF_LO   = 32;

endpackage

// File: rtl/lpi_half_merge.sv
// Merges a write into a stored register, either whole or one half.
// Assumes W is even; `upper` is meaningful only when `wide` is 0.
module lpi_half_merge #(
    parameter int W = 64
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] wr_val,
    input  logic         wide,
    input  logic         upper,
    output logic [W-1:0] merged
);
    localparam int H = W / 2;

    // Select which half of the stored value the write replaces
    always_comb begin
        if (wide) begin
            merged = wr_val;
        end else if (upper) begin
            merged = {wr_val[H-1:0], old_val[H-1:0]};
        end else begin
            merged = {old_val[W-1:H], wr_val[H-1:0]};
        end
    end
endmodule

// File: rtl/lpi_attr_clean.sv
// Rewrites the memory-attribute fields of a base register value to supported
// codes and clears the reserved bits. PEND picks the pending-table mask
// instead of the property-table mask. Purely combinational.
module lpi_attr_clean
    import lpi_frame_pkg::*;
#(
    parameter bit PEND = 1'b0
) (
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] clean
);
    logic [DATA_W-1:0] clr_mask;
    logic [SH_W-1:0]   sh_in;
    logic [SH_W-1:0]   sh_out;
    logic [IC_W-1:0]   ic_in;
    logic [IC_W-1:0]   ic_out;
    logic [OC_W-1:0]   oc_in;
    logic [OC_W-1:0]   oc_out;

    // Pick the reserved-bit mask for the table kind
    generate
        if (PEND) begin : g_pend_mask
            assign clr_mask = PEND_CLR;
        end else begin : g_prop_mask
            assign clr_mask = PROP_CLR;
        end
    endgenerate

    assign sh_in = raw[SH_LO +: SH_W];
    assign ic_in = raw[IC_LO +: IC_W];
    assign oc_in = raw[OC_LO +: OC_W];

    // Shareability: outer is demoted to inner
    always_comb begin
        sh_out = (sh_in == SH_OUTER) ? SH_INNER : sh_in;
    end

    // Inner cacheability: device and non-cacheable become write-back
    always_comb begin
        if (ic_in == IC_DEVICE || ic_in == IC_NONCACHE) begin
            ic_out = IC_RAWB;
        end else begin
            ic_out = ic_in;
        end
    end

    // Outer cacheability: only same-as-inner and non-cacheable survive
    always_comb begin
        if (oc_in == OC_SAME || oc_in == OC_NONCACHE) begin
            oc_out = oc_in;
        end else begin
            oc_out = OC_NONCACHE;
        end
    end

    // Reassemble the value and drop the reserved bits
    always_comb begin
        clean = raw;
        clean[SH_LO +: SH_W] = sh_out;
        clean[IC_LO +: IC_W] = ic_out;
        clean[OC_LO +: OC_W] = oc_out;
        clean = clean & ~clr_mask;
    end
endmodule

// File: rtl/lpi_base_reg.sv
// One 64-bit table base register: half/full merge, attribute cleaning and
// storage. A write is dropped while `lock` is high.
module lpi_base_reg
    import lpi_frame_pkg::*;
#(
    parameter bit PEND = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              lock,
    input  logic              wide,
    input  logic              upper,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] cleaned;

    lpi_half_merge #(.W(DATA_W)) u_merge (
        .old_val (q),
        .wr_val  (wdata),
        .wide    (wide),
        .upper   (upper),
        .merged  (merged)
    );

    lpi_attr_clean #(.PEND(PEND)) u_clean (
        .raw   (merged),
        .clean (cleaned)
    );

    // Store the cleaned value unless locked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en && !lock) begin
            q <= cleaned;
        end
    end
endmodule

// File: rtl/lpi_ctrl_reg.sv
// LPI-enable control bit with a rise pulse. Writes take effect only when
// the message-interrupt option is built in (HAS_MSI).
module lpi_ctrl_reg #(
    parameter bit HAS_MSI = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    output logic en,
    output logic pulse
);
    logic accept;

    assign accept = wr_en && HAS_MSI;

    // Hold the enable bit and flag its 0-to-1 change for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= accept && wr_val && !en;
            if (accept) begin
                en <= wr_val;
            end
        end
    end
endmodule

// File: rtl/lpi_redist_frame.sv
// Per-core LPI register frame. The slot is decoded from address bits 4:3;
// bit 2 picks the half for 32-bit accesses. Reads are combinational; writes
// land at the next edge. Assumes ADDR_W >= 6.
module lpi_redist_frame
    import lpi_frame_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter bit HAS_MSI    = 1'b1,
    parameter int CORE_W     = 16,
    parameter int AFF_W      = 24,
    parameter int CORE_ID    = 0,
    parameter int CORE_COUNT = 1,
    parameter int AFFINITY   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              lpi_en,
    output logic              lpi_en_pulse
);
    localparam int                 NUM_BASE = 2;
    localparam logic [AFF_W-1:0]   AFF_V    = AFF_W'(AFFINITY);
    localparam logic [CORE_W-1:0]  CORE_V   = CORE_W'(CORE_ID);
    localparam bit                 IS_LAST  = (CORE_ID == CORE_COUNT - 1);
    localparam logic [DATA_W-1:0]  TYPE_WORD =
        (DATA_W'(AFF_V) << TY_AFF_LO) |
        (DATA_W'(CORE_V) << TY_CORE_LO) |
        (DATA_W'(IS_LAST) << TY_LAST_BIT) |
        (DATA_W'(HAS_MSI) << TY_PLPI_BIT);

    slot_e             slot;
    logic              aligned;
    logic              in_frame;
    logic              hit;
    logic              wr_hit;
    logic              eff_hi;
    logic              ctrl_we;
    logic              base_we [NUM_BASE];
    logic [DATA_W-1:0] base_q  [NUM_BASE];
    logic [DATA_W-1:0] prop_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] word;

    // Decode the request address
    assign slot     = slot_e'(req_addr[SLOT_LO +: SLOT_W]);
    assign aligned  = (req_addr[HALF_BIT-1:0] == '0);
    assign in_frame = (req_addr[ADDR_W-1:FRAME_BITS] == '0);
    assign hit      = req_valid && aligned && in_frame;
    assign wr_hit   = hit && req_write;
    assign eff_hi   = !req_wide && req_addr[HALF_BIT];

    assign ctrl_we    = wr_hit && (slot == SLOT_CTRL) && !eff_hi;
    assign base_we[0] = wr_hit && (slot == SLOT_PROP);
    assign base_we[1] = wr_hit && (slot == SLOT_PEND);

    lpi_ctrl_reg #(.HAS_MSI(HAS_MSI)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_we),
        .wr_val (req_wdata[CTRL_EN_BIT]),
        .en     (lpi_en),
        .pulse  (lpi_en_pulse)
    );

    // One base register per table; index 1 is the pending table
    generate
        for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
            lpi_base_reg #(.PEND(g == 1)) u_base (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (base_we[g]),
                .lock  (lpi_en),
                .wide  (req_wide),
                .upper (eff_hi),
                .wdata (req_wdata),
                .q     (base_q[g])
            );
        end
    endgenerate

    assign prop_q = base_q[0];
    assign pend_q = base_q[1];

    // Select the full 64-bit word of the addressed slot
    always_comb begin
        unique case (slot)
            SLOT_CTRL: word = DATA_W'(lpi_en) << CTRL_EN_BIT;
            SLOT_TYPE: word = TYPE_WORD;
            SLOT_PROP: word = prop_q;
            default:   word = pend_q;
        endcase
    end

    // Narrow to the selected half for 32-bit reads; zero when no read
    always_comb begin
        if (!hit || req_write) begin
            rd_data = '0;
        end else if (req_wide) begin
            rd_data = word;
        end else if (eff_hi) begin
            rd_data = {{HALF_W{1'b0}}, word[DATA_W-1:HALF_W]};
        end else begin
            rd_data = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/lpi_redist_frame_chk.sv
// Property checker for the LPI register frame, attached by bind.
module lpi_redist_frame_chk
    import lpi_frame_pkg::*;
#(
    parameter bit HAS_MSI = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lpi_en,
    input logic              lpi_en_pulse,
    input logic [DATA_W-1:0] prop_q,
    input logic [DATA_W-1:0] pend_q
);
    // R1: no option, no enable
    a_r1_option_gates_enable: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_en |-> HAS_MSI);

    // R2: the pulse appears only on a fresh enable
    a_r2_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_en_pulse |-> (lpi_en && !$past(lpi_en)));

    // R2: every fresh enable carries a pulse
    a_r2_rise_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_en) |-> lpi_en_pulse);

    // R3: the base registers are frozen while enabled
    a_r3_frozen_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_en |=> ($stable(prop_q) && $stable(pend_q)));

    // R5: outer-shareable is never stored
    a_r5_no_outer_share: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_q[SH_LO +: SH_W] != SH_OUTER) && (pend_q[SH_LO +: SH_W] != SH_OUTER));

    // R7: only legal outer cacheability codes are stored
    a_r7_outer_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_q[OC_LO +: OC_W] <= OC_NONCACHE) && (pend_q[OC_LO +: OC_W] <= OC_NONCACHE));

    // R8: reserved bits stay clear
    a_r8_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((prop_q & PROP_CLR) == '0) && ((pend_q & PEND_CLR) == '0));
endmodule

bind lpi_redist_frame lpi_redist_frame_chk #(.HAS_MSI(HAS_MSI)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lpi_en       (lpi_en),
    .lpi_en_pulse (lpi_en_pulse),
    .prop_q       (prop_q),
    .pend_q       (pend_q)
);

// File: tb/lpi_redist_frame_test.sv
// Bench: two configurations driven with the same requests, compared against
// a behavioural reference on every cycle, plus directed checks.
module lpi_redist_frame_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rd_a, rd_b;
    logic        en_a, en_b, pl_a, pl_b;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_tag = "R11";

    // Reference model state, index 0 = uut, 1 = uut_b
    logic [63:0] m_prop [2];
    logic [63:0] m_pend [2];
    bit          m_en   [2];
    bit          m_pl   [2];
    bit          cfg_msi  [2] = '{1'b1, 1'b0};
    int          cfg_core [2] = '{3, 1};
    int          cfg_aff  [2] = '{32'h12_3456, 32'h00_0A0B};
    localparam int CORES = 4;

    always #4 clk = ~clk;

    lpi_redist_frame #(.HAS_MSI(1'b1), .CORE_ID(3), .CORE_COUNT(CORES),
                       .AFFINITY(32'h12_3456)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_a), .lpi_en(en_a), .lpi_en_pulse(pl_a));

    lpi_redist_frame #(.HAS_MSI(1'b0), .CORE_ID(1), .CORE_COUNT(CORES),
                       .AFFINITY(32'h00_0A0B)) uut_b (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_b), .lpi_en(en_b), .lpi_en_pulse(pl_b));

    function automatic logic [63:0] ref_clean(logic [63:0] v, bit pend);
        logic [63:0] r = v;
        logic [1:0]  sh = v[11:10];
        logic [2:0]  ic = v[9:7];
        logic [2:0]  oc = v[58:56];
        if (sh == 2'd2) sh = 2'd1;
        if (ic < 3'd2) ic = 3'd7;
        if (oc > 3'd1) oc = 3'd1;
        r[11:10] = sh; r[9:7] = ic; r[58:56] = oc;
        for (int b = 0; b < 64; b++) begin
            bit z = (b >= 48 && b <= 55);
            if (pend) z = z || b == 63 || (b >= 59 && b <= 61) || (b >= 12 && b <= 15) || b <= 6;
            else      z = z || b >= 59 || b == 5 || b == 6;
            if (z) r[b] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_type(int k);
        logic [63:0] t = 64'd0;
        t[55:32] = cfg_aff[k][23:0];
        t[23:8]  = cfg_core[k][15:0];
        t[4]     = (cfg_core[k] == CORES - 1);
        t[0]     = cfg_msi[k];
        return t;
    endfunction

    function automatic logic [63:0] ref_merge(logic [63:0] o);
        if (req_wide) return req_wdata;
        if (req_addr[2]) return {req_wdata[31:0], o[31:0]};
        return {o[63:32], req_wdata[31:0]};
    endfunction

    function automatic logic [63:0] ref_read(int k);
        logic [63:0] w;
        if (!req_valid || req_write || req_addr[1:0] != 0 || req_addr[5]) return 64'd0;
        case (req_addr[4:3])
            2'd0: w = {63'd0, m_en[k]};
            2'd1: w = ref_type(k);
            2'd2: w = m_prop[k];
            default: w = m_pend[k];
        endcase
        if (req_wide) return w;
        return req_addr[2] ? {32'd0, w[63:32]} : {32'd0, w[31:0]};
    endfunction

    // Reference update at each edge
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_prop[k] = 64'd0; m_pend[k] = 64'd0; m_en[k] = 1'b0; m_pl[k] = 1'b0;
            end else begin
                m_pl[k] = 1'b0;
                if (req_valid && req_write && req_addr[1:0] == 0 && !req_addr[5]) begin
                    case (req_addr[4:3])
                        2'd0: if (cfg_msi[k] && (req_wide || !req_addr[2])) begin
                            m_pl[k] = req_wdata[0] && !m_en[k];
                            m_en[k] = req_wdata[0];
                        end
                        2'd2: if (!m_en[k]) m_prop[k] = ref_clean(ref_merge(m_prop[k]), 1'b0);
                        2'd3: if (!m_en[k]) m_pend[k] = ref_clean(ref_merge(m_pend[k]), 1'b1);
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_tag, rd_a, ref_read(0));
            chk(cur_tag, rd_b, ref_read(1));
            chk("R1", {63'd0, en_a}, {63'd0, m_en[0]});
            chk("R1", {63'd0, en_b}, {63'd0, m_en[1]});
            chk("R2", {63'd0, pl_a}, {63'd0, m_pl[0]});
            chk("R2", {63'd0, pl_b}, {63'd0, m_pl[1]});
        end
    end

    task automatic drive(bit v, bit w, bit wide, logic [5:0] a, logic [63:0] d, string tag);
        @(posedge clk); #1;
        req_valid = v; req_write = w; req_wide = wide; req_addr = a; req_wdata = d;
        cur_tag = tag;
    endtask

    task automatic rd_expect(bit wide, logic [5:0] a, logic [63:0] ea, logic [63:0] eb, string tag);
        drive(1'b1, 1'b0, wide, a, 64'd0, tag);
        @(negedge clk);
        chk(tag, rd_a, ea);
        chk(tag, rd_b, eb);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2469;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11: reset state
        rd_expect(1'b1, 6'h00, 64'd0, 64'd0, "R11");
        rd_expect(1'b1, 6'h10, 64'd0, 64'd0, "R11");
        rd_expect(1'b1, 6'h18, 64'd0, 64'd0, "R11");
        // R9: type word, whole and upper half
        rd_expect(1'b1, 6'h08, 64'h0012_3456_0000_0311, 64'h0000_0A0B_0000_0100, "R9");
        rd_expect(1'b0, 6'h0C, 64'h0000_0000_0012_3456, 64'h0000_0000_0000_0A0B, "R9");
        // R8: all-ones writes
        drive(1'b1, 1'b1, 1'b1, 6'h10, '1, "R8");
        rd_expect(1'b1, 6'h10, 64'h0100_FFFF_FFFF_FF9F, 64'h0100_FFFF_FFFF_FF9F, "R8");
        drive(1'b1, 1'b1, 1'b1, 6'h18, '1, "R8");
        rd_expect(1'b1, 6'h18, 64'h4100_FFFF_FFFF_0F80, 64'h4100_FFFF_FFFF_0F80, "R8");
        // R5 R6 R7: remapped attribute codes
        drive(1'b1, 1'b1, 1'b1, 6'h10, 64'h0300_0000_0000_1800, "R5");
        rd_expect(1'b1, 6'h10, 64'h0100_0000_0000_1780, 64'h0100_0000_0000_1780, "R6");
        drive(1'b1, 1'b1, 1'b1, 6'h18, 64'h0000_00AB_CDEF_0080, "R7");
        rd_expect(1'b1, 6'h18, 64'h0000_00AB_CDEF_0380, 64'h0000_00AB_CDEF_0380, "R6");
        // R4: upper-half write, then narrow reads of each half
        drive(1'b1, 1'b1, 1'b0, 6'h1C, 64'hDEAD_BEEF_4000_0022, "R4");
        rd_expect(1'b0, 6'h1C, 64'h4000_0022, 64'h4000_0022, "R4");
        rd_expect(1'b0, 6'h18, 64'hCDEF_0380, 64'hCDEF_0380, "R4");
        // R9 R10: type write ignored, unmapped and unaligned read zero
        drive(1'b1, 1'b1, 1'b1, 6'h08, '1, "R9");
        rd_expect(1'b1, 6'h08, 64'h0012_3456_0000_0311, 64'h0000_0A0B_0000_0100, "R9");
        rd_expect(1'b1, 6'h20, 64'd0, 64'd0, "R10");
        rd_expect(1'b1, 6'h11, 64'd0, 64'd0, "R10");
        drive(1'b1, 1'b1, 1'b1, 6'h11, '1, "R10");
        rd_expect(1'b1, 6'h10, 64'h0100_0000_0000_1780, 64'h0100_0000_0000_1780, "R10");
        drive(1'b0, 1'b0, 1'b0, 6'h10, 64'd0, "R10");
        @(negedge clk);
        chk("R10", rd_a, 64'd0);
        // R1 R2: enable and its pulse
        drive(1'b1, 1'b1, 1'b0, 6'h00, 64'd1, "R1");
        drive(1'b0, 1'b0, 1'b0, 6'h00, 64'd0, "R2");
        @(negedge clk);
        chk("R2", {63'd0, pl_a}, 64'd1);
        chk("R1", {63'd0, en_a}, 64'd1);
        chk("R1", {63'd0, en_b}, 64'd0);
        drive(1'b1, 1'b1, 1'b0, 6'h00, 64'd1, "R2");
        drive(1'b0, 1'b0, 1'b0, 6'h00, 64'd0, "R2");
        @(negedge clk);
        chk("R2", {63'd0, pl_a}, 64'd0);
        // R3: lockout on uut only
        drive(1'b1, 1'b1, 1'b1, 6'h10, '1, "R3");
        rd_expect(1'b1, 6'h10, 64'h0100_0000_0000_1780, 64'h0100_FFFF_FFFF_FF9F, "R3");
        drive(1'b1, 1'b1, 1'b0, 6'h00, 64'd0, "R1");
        drive(1'b1, 1'b1, 1'b1, 6'h10, 64'h0000_0000_1234_5000, "R3");
        rd_expect(1'b1, 6'h10, 64'h0000_0000_1234_5380, 64'h0000_0000_1234_5380, "R3");
        // R4: pseudo-random mix
        for (int i = 0; i < 600; i++) begin
            logic [63:0] d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            d = {lfsr, lfsr ^ 32'h5A5A_C3C3};
            drive(1'b1, lfsr[7], lfsr[8], {lfsr[11] & lfsr[12], lfsr[4:2], lfsr[13] & lfsr[14] & lfsr[15], 1'b0},
                  (lfsr[4:3] == 2'd0) ? {63'd0, lfsr[9] & lfsr[10]} : d, "R4");
        end
        drive(1'b0, 1'b0, 1'b0, 6'h00, 64'd0, "R10");
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule